// File: doc/BRIEF.md
# Line Brown-Out Supervisor with Zero-Crossing Stop

This block decides whether a line-powered converter may switch. It watches three digitised line flags (line above the start level, line below the stop level, line near a zero crossing) and a supply-reset event, and it drives a single switching-permit output. After any reset the permit is withheld until the line has been seen above the start level. Once the converter is running, a sag below the stop level must persist without a break for a programmable number of clock cycles before a stop is requested.

A stop request does not end switching at once. The request is latched, switching goes on, and the permit is only withdrawn on the next zero-crossing indication. This lets the input filter discharge near a low point of the line before power delivery halts. If the line climbs back over the start level while the request is still pending, the request is dropped and running continues. After a stop the permit stays low until the line again rises above the start level. The whole supervision can be bypassed with an enable input. The current state is visible on a one-hot status output.

The analog comparators and their thresholds are outside this block. Hysteresis comes from the use of two separate level flags. All flag inputs are assumed to be synchronous to `clk`.

Top module: `line_brownout_sup`

## Requirements
- R1: While `rst_n` is low and in the cycle after it, the state is WAIT_START and `permit_o` is 0. The state leaves WAIT_START only for RUN, and only on a clock edge at which `line_above_start_i` is 1.
- R2: In RUN, the state moves to PENDING_STOP on the clock edge at which `line_below_stop_i` has been sampled 1 on BLANK_TICKS consecutive edges, all spent in RUN. `permit_o` stays 1 in PENDING_STOP.
- R3: In PENDING_STOP without `line_above_start_i`, the state stays put (with `permit_o` = 1) until an edge at which `line_zero_cross_i` is 1. At that edge it moves to STOPPED, and `permit_o` is 0 from then on.
- R4: STOPPED holds, with `permit_o` = 0, until an edge at which `line_above_start_i` is 1. It then moves to RUN.
- R5: When `sup_enable_i` is 0 (and there is no reset event), the next state is RUN and `permit_o` is 1, whatever the line flags are. The sag count is cleared.
- R6: The sag count restarts from zero whenever `line_below_stop_i` is sampled 0, or the state is not RUN. A sag of BLANK_TICKS-1 edges, a gap, and another BLANK_TICKS-1 edges does not request a stop.
- R7: In PENDING_STOP, `line_above_start_i` = 1 returns the state to RUN. This takes priority over a zero crossing in the same cycle.
- R8: `state_o` is one-hot with WAIT_START = 4'b0001, RUN = 4'b0010, PENDING_STOP = 4'b0100 and STOPPED = 4'b1000. `permit_o` is 1 exactly in RUN and PENDING_STOP.
- R9: In RUN, `line_zero_cross_i` and `line_above_start_i` have no effect on the state.
- R10: A `supply_reset_i` pulse sampled at an edge puts the state in WAIT_START at that edge, even when `sup_enable_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_reset_i | input | 1 | Supply-reset event; returns the block to WAIT_START |
| sup_enable_i | input | 1 | 1 = supervision active; 0 = bypassed, permit held high |
| line_above_start_i | input | 1 | Line is above the start level |
| line_below_stop_i | input | 1 | Line is below the stop level |
| line_zero_cross_i | input | 1 | Line is near a zero crossing |
| permit_o | output | 1 | Switching permitted |
| state_o | output | 4 | One-hot current state |

## Verification
The bench goes after the following corner cases, and the symptom a wrong design would show in each:

- **Sag boundary.** A sag exactly BLANK_TICKS edges long must request a stop. One edge shorter must not. A counter that is off by one would stop early, or would miss the exact-length sag.
- **Interrupted sag.** A sag broken by a single clear sample must start counting afresh. A counter that is not cleared would request a stop after two short dips.
- **Recovery beats zero crossing.** A recovery and a zero crossing arriving in the same pending cycle must return to RUN. A design with the wrong priority would cut the permit while the line is healthy.
- **Resets and bypass.** A zero crossing seen while running must change nothing. A supply reset must override the bypass. Getting either wrong shows up as a lost permit or a permit that never drops.

// File: rtl/bo_pkg.sv
// Shared types for the line brown-out supervisor.
// Assumes: state encoding is one-hot and visible at the top-level status port.
package bo_pkg;

    localparam int BO_STATE_W = 4;

    typedef enum logic [BO_STATE_W-1:0] {
        ST_WAIT_START = 4'b0001,
        ST_RUN        = 4'b0010,
        ST_PEND_STOP  = 4'b0100,
        ST_STOPPED    = 4'b1000
    } bo_state_e;

    // Switching is allowed while running or while a stop is still pending.
    function automatic logic state_permits(input bo_state_e st);
        return (st == ST_RUN) || (st == ST_PEND_STOP);
    endfunction

endpackage

// File: rtl/bo_sag_timer.sv
// Sag qualification timer.
// Counts consecutive cycles with the below-stop flag high while counting is
// allowed, and signals expiry on the edge that completes BLANK_TICKS samples.
// Assumes: BLANK_TICKS >= 1; count_en_i drops in the cycle after expiry.
module bo_sag_timer #(
    parameter int BLANK_TICKS = 54
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en_i,
    input  logic below_i,
    output logic expire_o
);
    localparam int CNT_W = $clog2(BLANK_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BLANK_TICKS - 1);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(BLANK_TICKS);

    logic [CNT_W-1:0] sag_cnt;
    logic             counting;

    // Counting happens only on a sampled sag while the controller allows it.
    always_comb counting = count_en_i && below_i;

    // Expiry fires when this sample completes the required run.
    always_comb expire_o = counting && (sag_cnt == LAST_CNT);

    // Consecutive-sample counter, saturating, cleared by any break.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sag_cnt <= '0;
        end else if (counting) begin
            if (sag_cnt != MAX_CNT)
                sag_cnt <= sag_cnt + 1'b1;
        end else begin
            sag_cnt <= '0;
        end
    end

    // R6: a clear sample leaves no sag history behind
    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !below_i |=> (sag_cnt == '0));

    // R2: the count never runs past the blanking length
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sag_cnt <= MAX_CNT);

    // R2: with a run longer than one sample, expiry needs a sag on the previous edge too
    generate
        if (BLANK_TICKS > 1) begin : g_hist
            p_sag_history_r2: assert property (@(posedge clk) disable iff (!rst_n)
                expire_o |-> $past(below_i && count_en_i));
        end
    endgenerate

endmodule

// File: rtl/bo_state_ctrl.sv
// Supervisor state controller.
// Holds WAIT_START / RUN / PENDING_STOP / STOPPED, one-hot. A supply reset wins
// over the bypass, and the bypass wins over the line flags. In PENDING_STOP a
// recovery wins over a zero crossing.
// Assumes: expire_i comes from the sag timer and is only high while in RUN.
module bo_state_ctrl
    import bo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      supply_reset_i,
    input  logic      enable_i,
    input  logic      above_i,
    input  logic      zero_cross_i,
    input  logic      expire_i,
    output bo_state_e state_o,
    output logic      count_en_o
);
    bo_state_e state_q, state_d;

    // Sag counting is meaningful only while running under active supervision.
    always_comb count_en_o = (state_q == ST_RUN) && enable_i && !supply_reset_i;

    // Next-state selection with fixed priorities.
    always_comb begin
        state_d = state_q;
        if (supply_reset_i) begin
            state_d = ST_WAIT_START;
        end else if (!enable_i) begin
            state_d = ST_RUN;
        end else begin
            unique case (state_q)
                ST_WAIT_START: if (above_i)      state_d = ST_RUN;
                ST_RUN:        if (expire_i)     state_d = ST_PEND_STOP;
                ST_PEND_STOP: begin
                    if (above_i)                 state_d = ST_RUN;
                    else if (zero_cross_i)       state_d = ST_STOPPED;
                end
                ST_STOPPED:    if (above_i)      state_d = ST_RUN;
                default:                         state_d = ST_WAIT_START;
            endcase
        end
    end

    // State register, synchronous reset to WAIT_START.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_START;
        else        state_q <= state_d;
    end

    always_comb state_o = state_q;

    // R8: state stays one-hot
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q));

    // R3: STOPPED is only ever entered from a pending stop on a zero crossing
    p_stop_on_zc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && $past(state_q) != ST_STOPPED) |->
            ($past(state_q) == ST_PEND_STOP && $past(zero_cross_i)));

    // R1: WAIT_START holds without the start flag
    p_wait_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_START && enable_i && !above_i) |=> (state_q == ST_WAIT_START));

    // R4: STOPPED holds without the start flag
    p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED && enable_i && !supply_reset_i && !above_i) |=> (state_q == ST_STOPPED));

    // R5: bypass forces RUN
    p_bypass_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !supply_reset_i) |=> (state_q == ST_RUN));

    // R10: supply reset forces WAIT_START
    p_supply_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        supply_reset_i |=> (state_q == ST_WAIT_START));

    // R7: recovery wins over zero crossing while pending
    p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PEND_STOP && enable_i && !supply_reset_i && above_i) |=> (state_q == ST_RUN));

    // R9: RUN is left only through expiry, bypass or reset
    p_run_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !expire_i && !supply_reset_i) |=> (state_q == ST_RUN));

endmodule

// File: rtl/line_brownout_sup.sv
// Line brown-out supervisor, top level.
// Qualifies the line after reset, times sags, defers the stop to the next
// zero crossing and waits for recovery after a stop.
// Assumes: all flag inputs are synchronous to clk; BLANK_TICKS is in clock cycles.
module line_brownout_sup
    import bo_pkg::*;
#(
    parameter int BLANK_TICKS = 54
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  supply_reset_i,
    input  logic                  sup_enable_i,
    input  logic                  line_above_start_i,
    input  logic                  line_below_stop_i,
    input  logic                  line_zero_cross_i,
    output logic                  permit_o,
    output logic [BO_STATE_W-1:0] state_o
);
    logic      count_en;
    logic      sag_expire;
    bo_state_e cur_state;

    bo_sag_timer #(
        .BLANK_TICKS (BLANK_TICKS)
    ) u_sag_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_en_i (count_en),
        .below_i    (line_below_stop_i),
        .expire_o   (sag_expire)
    );

    bo_state_ctrl u_state_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_reset_i (supply_reset_i),
        .enable_i       (sup_enable_i),
        .above_i        (line_above_start_i),
        .zero_cross_i   (line_zero_cross_i),
        .expire_i       (sag_expire),
        .state_o        (cur_state),
        .count_en_o     (count_en)
    );

    // Permit and status both come straight from the state register.
    always_comb begin
        permit_o = state_permits(cur_state);
        state_o  = cur_state;
    end

    // R8: the permit is high exactly in RUN and PENDING_STOP
    p_permit_map_r8: assert property (@(posedge clk) disable iff (!rst_n)
        permit_o == (state_o[1] || state_o[2]));

endmodule

// File: tb/line_brownout_sup_tb_top.sv
// Self-checking bench: directed corners plus seeded random stimulus, compared
// each cycle against a bench-side reference model.
module line_brownout_sup_tb_top;
    import bo_pkg::*;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic srst = 1'b0, en = 1'b1, above = 1'b0, below = 1'b0, zc = 1'b0;
    logic       permit;
    logic [3:0] state;

    int n_checks = 0;
    int n_fails  = 0;

    bo_state_e m_state = ST_WAIT_START;
    int        m_cnt   = 0;
    string     m_tag   = "R1";

    always #2.5 clk = ~clk;

    line_brownout_sup #(.BLANK_TICKS(N)) dut_i (
        .clk                (clk),
        .rst_n              (rst_n),
        .supply_reset_i     (srst),
        .sup_enable_i       (en),
        .line_above_start_i (above),
        .line_below_stop_i  (below),
        .line_zero_cross_i  (zc),
        .permit_o           (permit),
        .state_o            (state)
    );

    // Reference next-state from the requirements.
    task automatic model_edge();
        if (!rst_n) begin
            m_state = ST_WAIT_START; m_cnt = 0; m_tag = "R1";
        end else if (srst) begin
            m_state = ST_WAIT_START; m_cnt = 0; m_tag = "R10";
        end else if (!en) begin
            m_state = ST_RUN; m_cnt = 0; m_tag = "R5";
        end else begin
            case (m_state)
                ST_WAIT_START: begin
                    m_tag = "R1"; m_cnt = 0;
                    if (above) m_state = ST_RUN;
                end
                ST_RUN: begin
                    if (below) begin
                        m_tag = "R2";
                        if (m_cnt == N - 1) begin m_state = ST_PEND_STOP; m_cnt = 0; end
                        else m_cnt = m_cnt + 1;
                    end else begin
                        m_tag = (zc || above) ? "R9" : "R6";
                        m_cnt = 0;
                    end
                end
                ST_PEND_STOP: begin
                    m_cnt = 0;
                    if (above) begin m_state = ST_RUN; m_tag = "R7"; end
                    else if (zc) begin m_state = ST_STOPPED; m_tag = "R3"; end
                    else m_tag = "R3";
                end
                default: begin
                    m_cnt = 0; m_tag = "R4";
                    if (above) m_state = ST_RUN;
                end
            endcase
        end
    endtask

    function automatic logic exp_permit(input bo_state_e s);
        return (s == ST_RUN) || (s == ST_PEND_STOP);
    endfunction

    // One cycle: drive at negedge, clock, compare at next negedge.
    task automatic step(input logic r, input logic s, input logic e,
                        input logic a, input logic b, input logic z);
        rst_n = r; srst = s; en = e; above = a; below = b; zc = z;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (state !== 4'(m_state) || permit !== exp_permit(m_state)) begin
            n_fails++;
            $display("FAIL %s: state=%b exp=%b permit=%b exp=%b",
                     m_tag, state, 4'(m_state), permit, exp_permit(m_state));
        end
        n_checks++;
        if ($countones(state) != 1) begin
            n_fails++;
            $display("FAIL R8: state=%b exp=one-hot", state);
        end
    endtask

    // Line idle and healthy-but-not-above: run n plain cycles.
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 0, 1, 0, 0, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL R1: watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        logic rb, ra, rz, rs, re;
        seed = 32'd20240611;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset state, with start flag present during reset
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, 0);
        idle(4);                          // R1: no start flag, stays waiting
        step(1, 0, 1, 1, 0, 0);           // R1: start flag -> RUN
        step(1, 0, 1, 0, 0, 1);           // R9: zero crossing in RUN ignored
        step(1, 0, 1, 1, 0, 0);           // R9: start flag in RUN ignored
        // R6: N-1 sag, gap, N-1 sag -> no stop
        for (int i = 0; i < N - 1; i++) step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 0, 0);
        for (int i = 0; i < N - 1; i++) step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 0, 0);
        // R2: exactly N sag samples -> PENDING_STOP on the Nth edge
        for (int i = 0; i < N; i++) step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 0);           // R3: pending holds, permit high
        step(1, 0, 1, 1, 0, 1);           // R7: recovery beats zero crossing
        for (int i = 0; i < N; i++) step(1, 0, 1, 0, 1, 0);
        step(1, 0, 1, 0, 1, 1);           // R3: zero crossing -> STOPPED
        idle(3);                          // R4: stays stopped
        step(1, 0, 1, 0, 0, 1);           // R4: zero crossing alone ignored
        step(1, 0, 1, 1, 0, 0);           // R4: recovery -> RUN
        step(1, 0, 0, 0, 1, 1);           // R5: bypass
        for (int i = 0; i < 2 * N; i++) step(1, 0, 0, 0, 1, 0); // R5: sag ignored
        step(1, 1, 0, 0, 0, 0);           // R10: supply reset beats bypass
        step(1, 0, 1, 0, 0, 0);           // R1: waiting after supply reset
        step(1, 0, 1, 1, 0, 0);
        step(0, 0, 1, 0, 0, 0);           // R1: mid-run reset
        step(1, 0, 1, 0, 0, 0);
        // Random phase with sticky flags.
        rb = 0; re = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 11) == 0) rb = ~rb;
            if ($urandom_range(0, 149) == 0) re = ~re;
            if (!re && $urandom_range(0, 9) == 0) re = 1;
            ra = ($urandom_range(0, 24) == 0);
            rz = ($urandom_range(0, 5) == 0);
            rs = ($urandom_range(0, 499) == 0);
            step(1, rs, re, ra, rb, rz);
        end
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule